// File: doc/BRIEF.md
# Backplane Window Mapping Controller

This controller points a host-side memory aperture at the register page of one on-chip core. Each core owns a 4 KB page on the backplane, and the pages start at a fixed base address. Given a core index, the controller computes the page address and writes it into one of two window registers. It then reads that register back to confirm the write took effect. Writes to the window are not trusted. If the value read back differs, the controller writes and reads again, up to a bounded number of attempts, and then reports success or failure.

The controller drives a simple request/acknowledge register-bus master port. An access is held on the port until the slave acknowledges it, and read data is sampled in the acknowledge cycle.

A separate combinational path converts a window value read elsewhere back into a core index. It flags values that do not name a legal page.

Top module: `bp_window_mapper`

## Requirements
- R1: The value written for core index i is 0x18000000 + i * 0x1000.
- R2: With `map_sel` = 0, every access of an operation uses configuration offset 0x80. With `map_sel` = 1, every access uses offset 0x84.
- R3: Every write access is immediately followed by a read access at the same offset. One attempt is one write plus one read.
- R4: When the read-back value differs from the target, the controller writes the target again and then reads again.
- R5: When the read-back value equals the target, `done` is high for exactly one cycle, `busy` falls in that same cycle, and no further access is made.
- R6: After 10 attempts that all mismatch, `err` is high for exactly one cycle, `busy` falls, and no further access is made. `done` and `err` are never high together.
- R7: A `map_req` that arrives while `busy` is high is ignored. The running operation keeps its target, and no extra attempt is made.
- R8: For a `dec_addr` of the form 0x18000000 + i * 0x1000 with i < 2^IDX_W, `dec_valid` is 1 and `dec_idx` is i.
- R9: A `dec_addr` below 0x18000000, one with any of bits [11:0] set, or one whose page index is 2^IDX_W or more gives `dec_valid` = 0 and `dec_idx` = 0.
- R10: While reset is held, `busy`, `done`, `err` and `bus_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_req | input | 1 | Start a mapping operation; sampled only while idle |
| map_idx | input | IDX_W | Core index to map |
| map_sel | input | 1 | Window select: 0 uses offset 0x80, 1 uses offset 0x84 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: window confirmed |
| err | output | 1 | One-cycle pulse: retry limit reached |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write access, 0 for a read access |
| bus_ofs | output | 8 | Configuration offset of the access |
| bus_wdata | output | 32 | Write data (the target window value) |
| bus_ack | input | 1 | Slave acknowledge; completes the current access |
| bus_rdata | input | 32 | Read data, valid while `bus_ack` is high on a read |
| dec_addr | input | 32 | Window value to convert back into an index |
| dec_idx | output | IDX_W | Recovered core index (0 when invalid) |
| dec_valid | output | 1 | `dec_addr` names a legal page |

## Verification
The bench builds the controller with IDX_W = 4 and leaves the retry limit at 10. With 16 cores, every index can be mapped through both windows, and every legal page can be decoded. Index 16 is the first out-of-range page, so it sits just past the sweep. The bench's slave model can drop a chosen number of writes. Dropping 9 writes lets the bench check success on the very last attempt, and dropping 10 lets it check failure at the limit. Starting a second request during an operation checks that the extra request is ignored.

// File: rtl/bpw_pkg.sv
package bpw_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 8;

    localparam logic [OFS_W-1:0] WIN0_OFS = 8'h80;
    localparam logic [OFS_W-1:0] WIN1_OFS = 8'h84;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bpw_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] value;
        logic [OFS_W-1:0]  ofs;
    } bpw_job_t;

    function automatic logic [OFS_W-1:0] win_offset(input logic sel);
        return sel ? WIN1_OFS : WIN0_OFS;
    endfunction

endpackage

// File: rtl/bpw_encode.sv
module bpw_encode
    import bpw_pkg::*;
#(
    parameter int               IDX_W      = 8,
    parameter int               PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] BASE      = 32'h1800_0000
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = BASE + (ADDR_W'(idx) << PAGE_SHIFT);
    end
endmodule

// File: rtl/bpw_decode.sv
module bpw_decode
    import bpw_pkg::*;
#(
    parameter int               IDX_W      = 8,
    parameter int               PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] BASE      = 32'h1800_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              valid
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] page;
    logic              below;
    logic              unaligned;
    logic              too_far;

    always_comb begin
        below     = addr < BASE;
        rel       = addr - BASE;
        unaligned = |addr[PAGE_SHIFT-1:0];
        page      = rel >> PAGE_SHIFT;
        too_far   = |page[ADDR_W-1:IDX_W];
        valid     = !below && !unaligned && !too_far;
        idx       = valid ? page[IDX_W-1:0] : '0;
    end
endmodule

// File: rtl/bpw_seq.sv
module bpw_seq
    import bpw_pkg::*;
#(
    parameter int MAX_TRIES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bpw_job_t          job_in,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [OFS_W-1:0]  bus_ofs,
    output logic [ADDR_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [ADDR_W-1:0] bus_rdata
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    bpw_state_e       state;
    bpw_job_t         job;
    logic [TRY_W-1:0] tries;
    logic [TRY_W-1:0] tries_nx;

    assign tries_nx = tries + TRY_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= '0;
            tries <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        job   <= job_in;
                        tries <= '0;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (bus_ack) state <= ST_READ;
                end
                ST_READ: begin
                    if (bus_ack) begin
                        tries <= tries_nx;
                        if (bus_rdata == job.value) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (tries_nx == TRY_W'(MAX_TRIES)) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_WRITE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = state != ST_IDLE;
    assign bus_req   = busy;
    assign bus_we    = state == ST_WRITE;
    assign bus_ofs   = job.ofs;
    assign bus_wdata = job.value;

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    a_r6_not_both: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    a_r6_tries_bounded: assert property (@(posedge clk) disable iff (rst)
        tries <= TRY_W'(MAX_TRIES));
    a_r5_idle_after_finish: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !bus_req);
    a_r3_read_follows_write: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_ack) |=> (bus_req && !bus_we));
    a_r7_target_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(bus_wdata) && $stable(bus_ofs)));
endmodule

// File: rtl/bp_window_mapper.sv
module bp_window_mapper
    import bpw_pkg::*;
#(
    parameter int                IDX_W      = 8,
    parameter int                MAX_TRIES  = 10,
    parameter int                PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] BASE       = 32'h1800_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_req,
    input  logic [IDX_W-1:0]  map_idx,
    input  logic              map_sel,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [OFS_W-1:0]  bus_ofs,
    output logic [ADDR_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [ADDR_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic [IDX_W-1:0]  dec_idx,
    output logic              dec_valid
);
    logic [ADDR_W-1:0] tgt_addr;
    bpw_job_t          job;

    bpw_encode #(.IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .BASE(BASE)) u_enc (
        .idx  (map_idx),
        .addr (tgt_addr)
    );

    assign job.value = tgt_addr;
    assign job.ofs   = win_offset(map_sel);

    bpw_seq #(.MAX_TRIES(MAX_TRIES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (map_req),
        .job_in    (job),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_ofs   (bus_ofs),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    bpw_decode #(.IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .BASE(BASE)) u_dec (
        .addr  (dec_addr),
        .idx   (dec_idx),
        .valid (dec_valid)
    );

    a_r2_offset_legal: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_ofs == WIN0_OFS || bus_ofs == WIN1_OFS));
endmodule

// File: tb/sim_bp_window_mapper.sv
module sim_bp_window_mapper;
    localparam int IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              map_req = 1'b0;
    logic [IDX_W-1:0]  map_idx = '0;
    logic              map_sel = 1'b0;
    logic              busy, done, err, bus_req, bus_we;
    logic [7:0]        bus_ofs;
    logic [31:0]       bus_wdata;
    logic              bus_ack = 1'b0;
    logic [31:0]       bus_rdata = '0;
    logic [31:0]       dec_addr = '0;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_valid;

    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    logic [31:0] win0 = '0, win1 = '0;
    int          drop_left = 0;
    int          wr_cnt = 0, rd_cnt = 0;
    logic [7:0]  want_ofs = 8'h80;
    logic        ofs_bad = 1'b0;
    logic        order_bad = 1'b0;
    logic        last_was_wr = 1'b0;

    always #4 clk = ~clk;

    bp_window_mapper #(.IDX_W(IDX_W)) u0 (
        .clk(clk), .rst(rst), .map_req(map_req), .map_idx(map_idx),
        .map_sel(map_sel), .busy(busy), .done(done), .err(err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_ofs(bus_ofs),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .dec_addr(dec_addr), .dec_idx(dec_idx), .dec_valid(dec_valid)
    );

    // slave model: acknowledges every access after one idle cycle
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
        end else if (bus_req && !bus_ack) begin
            bus_ack = 1'b1;
            if (bus_ofs != want_ofs) ofs_bad = 1'b1;
            if (bus_we) begin
                if (last_was_wr) order_bad = 1'b1;
                last_was_wr = 1'b1;
                wr_cnt++;
                if (drop_left > 0) drop_left--;
                else if (bus_ofs == 8'h84) win1 = bus_wdata;
                else win0 = bus_wdata;
            end else begin
                if (!last_was_wr) order_bad = 1'b1;
                last_was_wr = 1'b0;
                rd_cnt++;
                bus_rdata = (bus_ofs == 8'h84) ? win1 : win0;
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] page_addr(input int i);
        return 32'h1800_0000 + 32'(i) * 32'h1000;
    endfunction

    task automatic do_map(input int idx, input logic sel, input int drop,
                          input logic ok, input int tries);
        logic [31:0] w;
        int          n;
        win0 = '0; win1 = '0; drop_left = drop;
        wr_cnt = 0; rd_cnt = 0; ofs_bad = 0; order_bad = 0; last_was_wr = 0;
        want_ofs = sel ? 8'h84 : 8'h80;
        @(negedge clk);
        map_req = 1'b1; map_idx = IDX_W'(idx); map_sel = sel;
        @(negedge clk);
        map_req = 1'b0;
        check("R7 busy after request", 32'(busy), 1);
        n = 0;
        while (!done && !err && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(ok ? "R5 done pulse" : "R6 err pulse", 32'({done, err}),
              ok ? 32'h2 : 32'h1);
        check("R5 busy drops at finish", 32'(busy), 0);
        @(negedge clk);
        check("R5 R6 single-cycle pulse", 32'({done, err}), 0);
        @(negedge clk);
        check("R3 R4 attempts written", 32'(wr_cnt), 32'(tries));
        check("R3 one read per write", 32'(rd_cnt), 32'(wr_cnt));
        check("R3 write-read order", 32'(order_bad), 0);
        check("R2 offset", 32'(ofs_bad), 0);
        w = sel ? win1 : win0;
        check("R1 window value", w, ok ? page_addr(idx) : 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset outputs", 32'({busy, done, err, bus_req}), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 16; i++) do_map(i, 1'(i % 2), 0, 1'b1, 1);
        for (int d = 1; d <= 9; d++) do_map(d, 1'(d / 5), d, 1'b1, d + 1);
        do_map(7, 1'b0, 10, 1'b0, 10);
        do_map(15, 1'b1, 12, 1'b0, 10);

        // R7: second request during an operation is ignored
        win0 = '0; win1 = '0; drop_left = 2;
        wr_cnt = 0; rd_cnt = 0; ofs_bad = 0; order_bad = 0; last_was_wr = 0;
        want_ofs = 8'h80;
        @(negedge clk);
        map_req = 1'b1; map_idx = 4'd3; map_sel = 1'b0;
        @(negedge clk);
        map_req = 1'b0;
        repeat (3) @(negedge clk);
        map_req = 1'b1; map_idx = 4'd9; map_sel = 1'b1;
        @(negedge clk);
        map_req = 1'b0;
        repeat (30) @(negedge clk);
        check("R7 ignored request: busy", 32'(busy), 0);
        check("R7 ignored request: window0", win0, page_addr(3));
        check("R7 ignored request: window1", win1, 32'h0);
        check("R7 ignored request: attempts", 32'(wr_cnt), 3);

        // R8 / R9: decode sweep
        for (int i = 0; i < 16; i++) begin
            dec_addr = page_addr(i);
            #1;
            check("R8 decode valid", 32'(dec_valid), 1);
            check("R8 decode index", 32'(dec_idx), 32'(i));
            dec_addr = page_addr(i) + 32'(i + 1) * 32'h10;
            #1;
            check("R9 unaligned", 32'({dec_valid, dec_idx}), 0);
        end
        dec_addr = 32'h17FF_F000; #1;
        check("R9 below base", 32'({dec_valid, dec_idx}), 0);
        dec_addr = 32'h0000_0000; #1;
        check("R9 zero address", 32'({dec_valid, dec_idx}), 0);
        dec_addr = page_addr(16); #1;
        check("R9 index out of range", 32'({dec_valid, dec_idx}), 0);
        dec_addr = page_addr(300); #1;
        check("R9 far out of range", 32'({dec_valid, dec_idx}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule